// File: doc/BRIEF.md
# Power-Management Register Bridge

This block lets a host processor reach the 16-bit registers of a companion power-management device through a simple request/response serial link. A host write that falls inside a 4 KB window of the block's address space does not wait for the link. It is queued in a write FIFO, and the queued writes go out one after another. A read is posted. The host stores the target register address into a command register, and the block then fetches the value without further help from the host. The host polls a result register until its busy flag drops.

The result word holds the returned value and the register address that the far side echoes back, so software can spot a reply that belongs to another access. Software can see whether the write FIFO is full or empty. A read always waits behind every write that was queued before it, and writes queued after it wait for the read. A clock-enable output stays low while the block is idle, unless a configuration bit forces it on. A set of channel-enable bits is brought out to the hardware channels.

Top module: `pmic_reg_bridge`

## Requirements
- R1: A host write to offsets 0x8000..0x8FFF is queued and is sent on the link as a write. The link address is the offset minus 0x8000 (12 bits) and the link data is host data bits 15:0. Writes are sent in the order they were accepted. A write outside that window produces no link traffic.
- R2: A write inside the window that arrives while the FIFO is full is held with `host_ready` low until space frees. It is then accepted and is never lost.
- R3: Reading offset 0x30 returns bit 11 = FIFO full and bit 10 = FIFO empty. Both flags count only queued entries, not the one being sent.
- R4: Writing offset 0x28 starts a link read of address bits 11:0 of the written data. The host takes no further action.
- R5: Bit 31 of offset 0x2C reads 1 from the first host read that follows an accepted read command. It stays 1 until the link response has arrived.
- R6: Offset 0x2C returns the response data in bits 15:0 and the echoed 12-bit response address, zero-extended, in bits 30:16. A mismatching echo is reported unchanged.
- R7: A read command is sent on the link after every write accepted before it and before any write accepted after it.
- R8: A write to offset 0x28 while the busy bit is 1 is ignored. No extra link read occurs and the pending result is not changed.
- R9: Offset 0x40 enables channels 0..31, and bits 1:0 always read 0 because those are software channels. Bits 17:0 of offset 0x20C enable channels 32..49. `chn_en` shows channel i on bit i.
- R10: `clk_en` is 1 one cycle after bit 30 of offset 0x20 is 1, or one cycle after any write is queued, in flight or a read is busy. Otherwise it is 0.
- R11: After reset `clk_en` is 0, `chn_en` is 0, `host_ready` is 1, the status register reads empty and not full, and offsets 0x2C and 0x20 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Byte offset of the access |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Access accepted this cycle (low = wait-state) |
| host_rdata | output | 32 | Read data, valid the cycle after acceptance |
| lnk_valid | output | 1 | Link request valid |
| lnk_write | output | 1 | Link request is a write |
| lnk_addr | output | 12 | Link register address |
| lnk_wdata | output | 16 | Link write data (0 for reads) |
| lnk_ready | input | 1 | Link accepts the request |
| lnk_rsp_valid | input | 1 | Read response valid |
| lnk_rsp_addr | input | 12 | Echoed address of the response |
| lnk_rsp_data | input | 16 | Response data |
| chn_en | output | 50 | Channel enable bits |
| clk_en | output | 1 | Registered clock enable |

## Verification
The hardest situation to reach is a read command that is accepted while writes are still queued and the link is stalled. Writes must also arrive after that command, so that ordering in both directions is at stake. The bench holds the link slave's ready low, queues writes, posts the read, queues one more write and then releases the link. The FIFO-full wait-state is reached the same way. The slave stays stalled until the stage and every FIFO entry are occupied, and the next window write is issued while a parallel thread releases the link many cycles later.

// File: rtl/pmic_bridge_pkg.sv
package pmic_bridge_pkg;
  // register offsets decoded by software
  localparam int unsigned OFF_CFG0    = 32'h0020;
  localparam int unsigned OFF_RDCMD   = 32'h0028;
  localparam int unsigned OFF_RDWORD  = 32'h002C;
  localparam int unsigned OFF_FIFOSTS = 32'h0030;
  localparam int unsigned OFF_CHLO    = 32'h0040;
  localparam int unsigned OFF_CHHI    = 32'h020C;
  // bit positions visible to software
  localparam int BUSY_BIT  = 31;
  localparam int AON_BIT   = 30;
  localparam int FULL_BIT  = 11;
  localparam int EMPTY_BIT = 10;
  localparam int ECHO_W    = 15;
  localparam int SW_CHANS  = 2;
endpackage

// File: rtl/prb_wr_fifo.sv
module prb_wr_fifo #(
  parameter int DW    = 28,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
    if (pop)  dout      <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  a_r2_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r3_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

// File: rtl/prb_link_eng.sv
module prb_link_eng #(
  parameter int AW    = 12,
  parameter int DW    = 16,
  parameter int CW    = 3,
  parameter int EW    = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_empty,
  input  logic [CW-1:0]    fifo_count,
  input  logic [AW+DW-1:0] fifo_dout,
  output logic             fifo_pop,
  input  logic             cmd_wr,
  input  logic [AW-1:0]    cmd_addr,
  output logic [31:0]      rd_status,
  output logic             idle,
  output logic             lnk_valid,
  output logic             lnk_write,
  output logic [AW-1:0]    lnk_addr,
  output logic [DW-1:0]    lnk_wdata,
  input  logic             lnk_ready,
  input  logic             lnk_rsp_valid,
  input  logic [AW-1:0]    lnk_rsp_addr,
  input  logic [DW-1:0]    lnk_rsp_data
);
  logic            lv_q, lw_q, wait_q, pend_q, busy_q;
  logic [CW-1:0]   ahead_q;
  logic [AW-1:0]   raddr_q;
  logic [EW+DW-1:0] word_q;
  logic            take, stage_free, rd_due, issue_rd, issue_wr, accept;

  assign take       = lv_q && lnk_ready;
  assign stage_free = !lv_q && !wait_q;
  assign rd_due     = pend_q && (ahead_q == '0);
  assign issue_rd   = stage_free && rd_due;
  assign issue_wr   = stage_free && !rd_due && !fifo_empty;
  assign fifo_pop   = issue_wr;
  assign accept     = cmd_wr && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lv_q    <= 1'b0;
      lw_q    <= 1'b0;
      wait_q  <= 1'b0;
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      ahead_q <= '0;
      raddr_q <= '0;
      word_q  <= '0;
    end else begin
      if (accept) begin
        busy_q  <= 1'b1;
        pend_q  <= 1'b1;
        raddr_q <= cmd_addr;
        ahead_q <= fifo_count - CW'(fifo_pop);
      end else if (fifo_pop && pend_q) begin
        ahead_q <= ahead_q - CW'(1);
      end
      if (issue_rd) begin
        pend_q <= 1'b0;
        lv_q   <= 1'b1;
        lw_q   <= 1'b0;
      end
      if (issue_wr) begin
        lv_q <= 1'b1;
        lw_q <= 1'b1;
      end
      if (take) begin
        lv_q <= 1'b0;
        if (!lw_q) wait_q <= 1'b1;
      end
      if (wait_q && lnk_rsp_valid) begin
        wait_q <= 1'b0;
        busy_q <= 1'b0;
        word_q <= {EW'(lnk_rsp_addr), lnk_rsp_data};
      end
    end
  end

  assign rd_status = {busy_q, word_q};
  assign idle      = fifo_empty && !lv_q && !busy_q;
  assign lnk_valid = lv_q;
  assign lnk_write = lw_q;
  assign lnk_addr  = lw_q ? fifo_dout[AW+DW-1:DW] : raddr_q;
  assign lnk_wdata = lw_q ? fifo_dout[DW-1:0] : '0;

  a_r1_hold_request: assert property (@(posedge clk) disable iff (rst)
    lv_q && !lnk_ready |=> lv_q && $stable(lnk_addr) && $stable(lw_q) && $stable(lnk_wdata));
  a_r5_busy_until_response: assert property (@(posedge clk) disable iff (rst)
    busy_q && !(wait_q && lnk_rsp_valid) |=> busy_q);
  a_r7_read_after_older_writes: assert property (@(posedge clk) disable iff (rst)
    lv_q && !lw_q |-> ahead_q == '0 && busy_q);
  a_r8_command_ignored: assert property (@(posedge clk) disable iff (rst)
    busy_q && cmd_wr |=> $stable(raddr_q));
endmodule

// File: rtl/pmic_reg_bridge.sv
module pmic_reg_bridge #(
  parameter int HOST_AW    = 16,
  parameter int WIN_BASE   = 32'h8000,
  parameter int WIN_BYTES  = 4096,
  parameter int SLV_DW     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int N_CHAN     = 50,
  localparam int SLV_AW    = $clog2(WIN_BYTES),
  localparam int HI_CH     = N_CHAN - 32,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic               host_ready,
  output logic [31:0]        host_rdata,
  output logic               lnk_valid,
  output logic               lnk_write,
  output logic [SLV_AW-1:0]  lnk_addr,
  output logic [SLV_DW-1:0]  lnk_wdata,
  input  logic               lnk_ready,
  input  logic               lnk_rsp_valid,
  input  logic [SLV_AW-1:0]  lnk_rsp_addr,
  input  logic [SLV_DW-1:0]  lnk_rsp_data,
  output logic [N_CHAN-1:0]  chn_en,
  output logic               clk_en
);
  import pmic_bridge_pkg::*;

  localparam logic [HOST_AW:0]   WIN_LO  = (HOST_AW+1)'(WIN_BASE);
  localparam logic [HOST_AW:0]   WIN_HI  = (HOST_AW+1)'(WIN_BASE + WIN_BYTES);
  localparam logic [SLV_AW-1:0]  WIN_LSB = SLV_AW'(WIN_BASE);

  logic                    in_win, acc, push, cmd_wr, idle;
  logic                    f_full, f_empty, f_pop;
  logic [CW-1:0]           f_count;
  logic [SLV_AW+SLV_DW-1:0] f_dout;
  logic [SLV_AW-1:0]       slv_off;
  logic [31:0]             rd_status, cfg0_q, chlo_q, rmux;
  logic [HI_CH-1:0]        chhi_q;

  function automatic logic at(input logic [HOST_AW-1:0] a, input int unsigned off);
    return a == HOST_AW'(off);
  endfunction

  assign in_win     = ({1'b0, host_addr} >= WIN_LO) && ({1'b0, host_addr} < WIN_HI);
  assign host_ready = !(host_req && host_we && in_win && f_full);
  assign acc        = host_req && host_ready;
  assign push       = acc && host_we && in_win;
  assign cmd_wr     = acc && host_we && at(host_addr, OFF_RDCMD);
  assign slv_off    = host_addr[SLV_AW-1:0] - WIN_LSB;

  prb_wr_fifo #(.DW(SLV_AW + SLV_DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .din   ({slv_off, host_wdata[SLV_DW-1:0]}),
    .pop   (f_pop),
    .dout  (f_dout),
    .full  (f_full),
    .empty (f_empty),
    .count (f_count)
  );

  prb_link_eng #(.AW(SLV_AW), .DW(SLV_DW), .CW(CW), .EW(ECHO_W)) u_eng (
    .clk           (clk),
    .rst           (rst),
    .fifo_empty    (f_empty),
    .fifo_count    (f_count),
    .fifo_dout     (f_dout),
    .fifo_pop      (f_pop),
    .cmd_wr        (cmd_wr),
    .cmd_addr      (host_wdata[SLV_AW-1:0]),
    .rd_status     (rd_status),
    .idle          (idle),
    .lnk_valid     (lnk_valid),
    .lnk_write     (lnk_write),
    .lnk_addr      (lnk_addr),
    .lnk_wdata     (lnk_wdata),
    .lnk_ready     (lnk_ready),
    .lnk_rsp_valid (lnk_rsp_valid),
    .lnk_rsp_addr  (lnk_rsp_addr),
    .lnk_rsp_data  (lnk_rsp_data)
  );

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg0_q <= '0;
      chlo_q <= '0;
      chhi_q <= '0;
    end else if (acc && host_we) begin
      if (at(host_addr, OFF_CFG0)) cfg0_q <= host_wdata;
      if (at(host_addr, OFF_CHLO)) chlo_q <= {host_wdata[31:SW_CHANS], {SW_CHANS{1'b0}}};
      if (at(host_addr, OFF_CHHI)) chhi_q <= host_wdata[HI_CH-1:0];
    end
  end

  always_comb begin
    rmux = '0;
    if (at(host_addr, OFF_CFG0))    rmux = cfg0_q;
    if (at(host_addr, OFF_RDWORD))  rmux = rd_status;
    if (at(host_addr, OFF_FIFOSTS)) begin
      rmux[FULL_BIT]  = f_full;
      rmux[EMPTY_BIT] = f_empty;
    end
    if (at(host_addr, OFF_CHLO))    rmux = chlo_q;
    if (at(host_addr, OFF_CHHI))    rmux = 32'(chhi_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      clk_en     <= 1'b0;
    end else begin
      if (acc && !host_we) host_rdata <= rmux;
      clk_en <= cfg0_q[AON_BIT] || !idle;
    end
  end

  assign chn_en = {chhi_q, chlo_q};

  a_r2_stall_only_when_full: assert property (@(posedge clk) disable iff (rst)
    host_req && host_we && in_win && !host_ready |-> f_full);
  a_r9_sw_channels_off: assert property (@(posedge clk) disable iff (rst)
    chn_en[SW_CHANS-1:0] == '0);
  a_r10_clock_on_when_busy: assert property (@(posedge clk) disable iff (rst)
    lnk_valid |=> clk_en);
endmodule

// File: tb/pmic_reg_bridge_test.sv
`timescale 1ns/1ps
module pmic_reg_bridge_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        host_req, host_we;
  logic [15:0] host_addr;
  logic [31:0] host_wdata;
  logic        host_ready;
  logic [31:0] host_rdata;
  logic        lnk_valid, lnk_write, lnk_ready, lnk_rsp_valid;
  logic [11:0] lnk_addr, lnk_rsp_addr;
  logic [15:0] lnk_wdata, lnk_rsp_data;
  logic [49:0] chn_en;
  logic        clk_en;

  always #5 clk = ~clk;

  pmic_reg_bridge uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .lnk_valid(lnk_valid), .lnk_write(lnk_write),
    .lnk_addr(lnk_addr), .lnk_wdata(lnk_wdata), .lnk_ready(lnk_ready),
    .lnk_rsp_valid(lnk_rsp_valid), .lnk_rsp_addr(lnk_rsp_addr),
    .lnk_rsp_data(lnk_rsp_data), .chn_en(chn_en), .clk_en(clk_en)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] slv_val(input logic [11:0] a);
    return {a[3:0], a} ^ 16'h9C31;
  endfunction

  // ---------------- reference model, sampled at negedge ----------------
  logic [28:0] exp_q[$];
  int  m_wr_out, p_wr_inc, p_wr_dec;
  bit  m_busy, m_infl, m_aon, e_prev;
  bit  p_busy_set, p_busy_clr, p_infl_set, p_infl_clr, p_aon_set, p_aon_val;
  int  rd_hs_cnt = 0;

  always @(negedge clk) begin
    if (rst) begin
      exp_q.delete();
      m_wr_out = 0; m_busy = 0; m_infl = 0; m_aon = 0; e_prev = 0;
      p_wr_inc = 0; p_wr_dec = 0; p_busy_set = 0; p_busy_clr = 0;
      p_infl_set = 0; p_infl_clr = 0; p_aon_set = 0; p_aon_val = 0;
    end else begin
      m_wr_out += p_wr_inc - p_wr_dec;
      if (p_busy_set) m_busy = 1;
      if (p_busy_clr) m_busy = 0;
      if (p_infl_set) m_infl = 1;
      if (p_infl_clr) m_infl = 0;
      if (p_aon_set)  m_aon  = p_aon_val;
      p_wr_inc = 0; p_wr_dec = 0; p_busy_set = 0; p_busy_clr = 0;
      p_infl_set = 0; p_infl_clr = 0; p_aon_set = 0;

      chk(clk_en == e_prev, "R10 clk_en per cycle", clk_en, e_prev);
      e_prev = m_aon || (m_wr_out != 0) || m_busy;

      if (host_req && host_ready && host_we) begin
        if (host_addr >= 16'h8000 && host_addr < 16'h9000) begin
          exp_q.push_back({1'b1, host_addr[11:0], host_wdata[15:0]});
          p_wr_inc = 1;
        end else if (host_addr == 16'h0028 && !m_busy) begin
          exp_q.push_back({1'b0, host_wdata[11:0], 16'h0});
          p_busy_set = 1;
        end else if (host_addr == 16'h0020) begin
          p_aon_set = 1;
          p_aon_val = host_wdata[30];
        end
      end
      if (lnk_valid && lnk_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R1 unexpected link request", {lnk_write, lnk_addr, lnk_wdata}, 0);
        end else begin
          logic [28:0] e;
          e = exp_q.pop_front();
          chk({lnk_write, lnk_addr, lnk_wdata} == e, "R1 R7 link order/content",
              {lnk_write, lnk_addr, lnk_wdata}, e);
        end
        if (lnk_write) p_wr_dec = 1;
        else begin
          p_infl_set = 1;
          rd_hs_cnt++;
        end
      end
      if (lnk_rsp_valid && m_infl) begin
        p_infl_clr = 1;
        p_busy_clr = 1;
      end
    end
  end

  // ---------------- link slave ----------------
  bit  slv_hold = 0, slv_corrupt = 0;
  int  slv_served = 0, rd_cd = 0, cyc = 0;
  logic [11:0] slv_a;

  always @(posedge clk) begin
    #1;
    cyc++;
    lnk_ready = !slv_hold && (cyc % 4 != 3);
    lnk_rsp_valid = 1'b0;
    if (slv_served != rd_hs_cnt) begin
      slv_served = rd_hs_cnt;
      slv_a = lnk_addr;
      rd_cd = 4;
    end else if (rd_cd > 0) begin
      rd_cd--;
      if (rd_cd == 0) begin
        lnk_rsp_valid = 1'b1;
        lnk_rsp_addr  = slv_corrupt ? (slv_a ^ 12'h001) : slv_a;
        lnk_rsp_data  = slv_val(slv_a);
      end
    end
  end

  // ---------------- host tasks (start and end at posedge+1) ----------------
  task automatic hwr(input logic [15:0] a, input logic [31:0] d, output int waits);
    waits = 0;
    host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    while (!host_ready) begin
      waits++;
      @(negedge clk);
    end
    @(posedge clk); #1;
    host_req = 0; host_we = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    int w;
    hwr(a, d, w);
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    host_req = 1; host_we = 0; host_addr = a;
    @(negedge clk);
    @(posedge clk); #1;
    host_req = 0;
    @(negedge clk);
    d = host_rdata;
    @(posedge clk); #1;
  endtask

  task automatic poll(output logic [31:0] d);
    int k = 0;
    do begin
      rd(16'h002C, d);
      k++;
    end while (d[31] && k < 200);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int w, c0;
    rst = 1; host_req = 0; host_we = 0; host_addr = 0; host_wdata = 0;
    lnk_ready = 0; lnk_rsp_valid = 0; lnk_rsp_addr = 0; lnk_rsp_data = 0;
    repeat (4) @(posedge clk);
    #1 rst = 0;

    // R11 reset state
    @(negedge clk);
    chk(clk_en == 0, "R11 clk_en after reset", clk_en, 0);
    chk(chn_en == 0, "R11 chn_en after reset", chn_en, 0);
    chk(host_ready == 1, "R11 host_ready after reset", host_ready, 1);
    @(posedge clk); #1;
    rd(16'h0030, v);
    chk(v[10] == 1 && v[11] == 0, "R11 R3 status after reset", v, 32'h400);
    rd(16'h002C, v);
    chk(v == 0, "R11 result word after reset", v, 0);
    rd(16'h0020, v);
    chk(v == 0, "R11 cfg0 after reset", v, 0);

    // R1 window writes, edges and outside addresses
    wr(16'h8000, 32'hAAAA_1234);
    wr(16'h8FFE, 32'h0000_BEEF);
    wr(16'h9000, 32'h0000_1111);
    wr(16'h7FFC, 32'h0000_2222);
    wr(16'h8FFF, 32'h0000_0F0F);
    settle(30);
    chk(exp_q.size() == 0, "R1 all window writes delivered", exp_q.size(), 0);

    // R4 R5 R6 posted read
    c0 = rd_hs_cnt;
    wr(16'h0028, 32'h0000_8123);
    rd(16'h002C, v);
    chk(v[31] == 1, "R5 busy after command", v[31], 1);
    poll(v);
    chk(rd_hs_cnt == c0 + 1, "R4 one link read started", rd_hs_cnt, c0 + 1);
    chk(v == {1'b0, 3'b0, 12'h123, slv_val(12'h123)}, "R6 result word",
        v, {1'b0, 3'b0, 12'h123, slv_val(12'h123)});

    // R8 command while busy ignored
    c0 = rd_hs_cnt;
    wr(16'h0028, 32'h0000_00A5);
    wr(16'h0028, 32'h0000_00F0);
    poll(v);
    settle(10);
    chk(rd_hs_cnt == c0 + 1, "R8 only one link read", rd_hs_cnt, c0 + 1);
    chk(v[30:16] == 15'h0A5, "R8 result kept first address", v[30:16], 15'h0A5);

    // R7 ordering around a stalled link
    slv_hold = 1;
    wr(16'h8010, 32'h0000_0101);
    wr(16'h8020, 32'h0000_0202);
    wr(16'h0028, 32'h0000_0345);
    wr(16'h8030, 32'h0000_0303);
    settle(5);
    slv_hold = 0;
    poll(v);
    settle(20);
    chk(exp_q.size() == 0, "R7 all ordered requests delivered", exp_q.size(), 0);
    chk(v[15:0] == slv_val(12'h345), "R7 read data after writes", v[15:0], slv_val(12'h345));

    // R2 R3 full FIFO and wait-states
    slv_hold = 1;
    for (int i = 0; i < 5; i++) wr(16'h8100 + 16'(i * 2), 32'(16'h5000 + i));
    rd(16'h0030, v);
    chk(v[11] == 1 && v[10] == 0, "R3 status full", v, 32'h800);
    fork
      hwr(16'h8200, 32'h0000_6666, w);
      begin
        settle(20);
        slv_hold = 0;
      end
    join
    chk(w >= 10, "R2 write stalled while full", w, 10);
    settle(40);
    chk(exp_q.size() == 0, "R2 no write dropped", exp_q.size(), 0);
    rd(16'h0030, v);
    chk(v[11] == 0 && v[10] == 1, "R3 status empty after drain", v, 32'h400);

    // R9 channel enables
    wr(16'h0040, 32'hFFFF_FFFF);
    rd(16'h0040, v);
    chk(v == 32'hFFFF_FFFC, "R9 low enable readback", v, 32'hFFFF_FFFC);
    wr(16'h020C, 32'hFFFF_FFFF);
    rd(16'h020C, v);
    chk(v == 32'h0003_FFFF, "R9 high enable readback", v, 32'h0003_FFFF);
    chk(chn_en == {18'h3FFFF, 32'hFFFF_FFFC}, "R9 chn_en port", chn_en, {18'h3FFFF, 32'hFFFF_FFFC});
    wr(16'h0040, 32'h0000_0005);
    rd(16'h0040, v);
    chk(v == 32'h0000_0004, "R9 software channel bits zero", v, 4);

    // R10 clock forcing
    wr(16'h0020, 32'h4000_0000);
    settle(3);
    @(negedge clk);
    chk(clk_en == 1, "R10 forced on while idle", clk_en, 1);
    @(posedge clk); #1;
    rd(16'h0020, v);
    chk(v == 32'h4000_0000, "R10 cfg0 readback", v, 32'h4000_0000);
    wr(16'h0020, 32'h0);
    settle(3);
    @(negedge clk);
    chk(clk_en == 0, "R10 gated while idle", clk_en, 0);
    @(posedge clk); #1;

    // R6 mismatching echo reported
    slv_corrupt = 1;
    wr(16'h0028, 32'h0000_0456);
    poll(v);
    slv_corrupt = 0;
    chk(v[30:16] == 15'h457, "R6 mismatching echo visible", v[30:16], 15'h457);
    chk(v[15:0] == slv_val(12'h456), "R6 data field", v[15:0], slv_val(12'h456));

    settle(10);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule